// File: doc/BRIEF.md
# Flash Status-Polling Completion Engine

This block runs on the host side of a parallel flash. Once the host has written a program or erase command sequence, it hands the engine a start request with the target address, the data that was written and an erase/program selector. The engine then reads that address over and over through a request/acknowledge bus master. It watches bit 7 of each returned word. While the device's internal algorithm is still running, that bit reads as the complement of its final value.

A match on bit 7 is never taken as final. On the cycle where the status bit flips, the other data bits may still be settling. The engine therefore always issues one more confirming read, and it judges the full word from that read alone. A programmable limit on elapsed polling clocks bounds the wait, so a device that never completes ends in a timeout and not in a hang.

For erase polling, the caller must pass an address that lies inside a sector being erased and that is not protected. The engine reads only the address it was given.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset, and whenever the engine is idle, busy_o, done_o, timeout_o, mismatch_o and rd_req_o are all low.
- R2: For a program operation (start_erase_i=0), the status bit that must be observed is bit 7 of start_data_i. Reads whose bit 7 differs from that value keep the engine polling.
- R3: For an erase operation (start_erase_i=1), the expected word is all ones, so the expected status bit is 1. The value on start_data_i is ignored.
- R4: After the first read whose bit 7 matches, exactly one further read is issued. done_o rises in the cycle after that read's acknowledge, and no other read follows it.
- R5: mismatch_o is high together with done_o exactly when the confirming read's full 32-bit word differs from the expected word. It is never high without done_o.
- R6: rd_req_o stays high, and rd_addr_o stays unchanged, until a cycle with rd_ack_i high. Read data is sampled in that cycle. Every read of an operation uses the address latched at start.
- R7: Clocks spent in the polling states (waiting on a read and evaluating it) are counted from start. A non-matching evaluation taken when that count is at least the latched limit raises timeout_o and issues no further read. A limit of 0 times out on the first non-matching read.
- R8: start_i is accepted only while busy_o is low. busy_o rises in the cycle after an accepted start and falls in the cycle after the done_o or timeout_o pulse. A start request while busy changes nothing.
- R9: done_o and timeout_o are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| start_addr_i | input | ADDR_W | Address to poll |
| start_data_i | input | DATA_W | Data written by the program command |
| start_erase_i | input | 1 | 1 selects erase polling |
| tmo_limit_i | input | TMO_W | Polling clock limit |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_ack_i | input | 1 | Read acknowledge, data valid |
| rd_data_i | input | DATA_W | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| timeout_o | output | 1 | Timeout pulse |
| mismatch_o | output | 1 | Confirmed word differs from expected, valid with done_o |

## Verification
The hardest case to reach is a read where the status bit has just turned correct but the other bits are still wrong. A design that trusts this read would report a false mismatch, or report done one read early. The bench acts as the flash model and scripts a sequence for each operation: status reads with the inverted bit 7, then a single transition word with bit 7 right and other bits scrambled, then a final word that is either correct or deliberately corrupted. The sequences run with and without acknowledge wait states, and a cycle-level reference model flags any early completion, extra read or wrong flag.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_CHECK, ST_CONFIRM, ST_DONE, ST_TIMEOUT
  } poll_state_e;
endpackage

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             tick_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic [CNT_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= limit_i;
    end else if (tick_i && cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + 1'b1;  // saturating
    end
  end

  assign expired_o = (cnt_q >= lim_q);
endmodule

// File: rtl/poll_match.sv
module poll_match #(
  parameter int DATA_W   = 32,
  parameter int FLAG_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              erase_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              flag_hit_o,
  output logic              word_miss_o
);
  logic [DATA_W-1:0] exp_q, got_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q <= '0;
      got_q <= '0;
    end else begin
      if (load_i)    exp_q <= erase_i ? '1 : data_i;  // erased cells read all ones
      if (capture_i) got_q <= rd_data_i;
    end
  end

  assign flag_hit_o  = (got_q[FLAG_BIT] == exp_q[FLAG_BIT]);
  assign word_miss_o = (got_q != exp_q);
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
  import flash_poll_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rd_ack_i,
  input  logic        flag_hit_i,
  input  logic        expired_i,
  output poll_state_e state_o,
  output logic        load_o,
  output logic        capture_o,
  output logic        tick_o
);
  poll_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (start_i) st_d = ST_READ;
      ST_READ:    if (rd_ack_i) st_d = ST_CHECK;
      ST_CHECK: begin
        if (flag_hit_i)     st_d = ST_CONFIRM;
        else if (expired_i) st_d = ST_TIMEOUT;
        else                st_d = ST_READ;
      end
      ST_CONFIRM: if (rd_ack_i) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      ST_TIMEOUT: st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o   = st_q;
  assign load_o    = (st_q == ST_IDLE) && start_i;
  assign capture_o = ((st_q == ST_READ) || (st_q == ST_CONFIRM)) && rd_ack_i;
  assign tick_o    = (st_q == ST_READ) || (st_q == ST_CHECK);
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine
  import flash_poll_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = 32,
  parameter int FLAG_BIT = 7,
  parameter int TMO_W    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [DATA_W-1:0] start_data_i,
  input  logic              start_erase_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic              rd_ack_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              mismatch_o
);
  poll_state_e       state;
  logic              load, capture, tick, flag_hit, word_miss, expired;
  logic [ADDR_W-1:0] addr_q;

  poll_fsm u_fsm (
    .clk_i, .rst_ni, .start_i, .rd_ack_i,
    .flag_hit_i(flag_hit), .expired_i(expired),
    .state_o(state), .load_o(load), .capture_o(capture), .tick_o(tick)
  );

  poll_match #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_match (
    .clk_i, .rst_ni, .load_i(load), .erase_i(start_erase_i),
    .data_i(start_data_i), .capture_i(capture), .rd_data_i,
    .flag_hit_o(flag_hit), .word_miss_o(word_miss)
  );

  poll_timer #(.CNT_W(TMO_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .limit_i(tmo_limit_i),
    .tick_i(tick), .expired_o(expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   addr_q <= '0;
    else if (load) addr_q <= start_addr_i;
  end

  assign rd_addr_o  = addr_q;
  assign rd_req_o   = (state == ST_READ) || (state == ST_CONFIRM);
  assign busy_o     = (state != ST_IDLE);
  assign done_o     = (state == ST_DONE);
  assign timeout_o  = (state == ST_TIMEOUT);
  assign mismatch_o = (state == ST_DONE) && word_miss;
endmodule

// File: rtl/flash_poll_engine_chk.sv
module flash_poll_engine_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              rd_req_o,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              rd_ack_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              timeout_o,
  input logic              mismatch_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o && !done_o && !timeout_o);
  assert_done_after_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(rd_ack_i) && !rd_req_o);
  assert_miss_with_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mismatch_o |-> done_o);
  assert_req_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));
  assert_tmo_no_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !rd_req_o);
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(rd_addr_o));
  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_tmo_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);
endmodule

bind flash_poll_engine flash_poll_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .rd_req_o(rd_req_o),
  .rd_addr_o(rd_addr_o), .rd_ack_i(rd_ack_i), .busy_o(busy_o), .done_o(done_o),
  .timeout_o(timeout_o), .mismatch_o(mismatch_o)
);

// File: tb/flash_poll_engine_bench.sv
module flash_poll_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] start_addr_i = '0;
  logic [31:0] start_data_i = '0;
  logic        start_erase_i = 1'b0;
  logic [15:0] tmo_limit_i = '0;
  logic        rd_ack_i = 1'b0;
  logic [31:0] rd_data_i = '0;
  logic        rd_req_o, busy_o, done_o, timeout_o, mismatch_o;
  logic [23:0] rd_addr_o;

  int vectors = 0, fails = 0;

  always #2 clk = ~clk;

  flash_poll_engine u_flash_poll_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .start_addr_i, .start_data_i,
    .start_erase_i, .tmo_limit_i, .rd_req_o, .rd_addr_o, .rd_ack_i, .rd_data_i,
    .busy_o, .done_o, .timeout_o, .mismatch_o
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // flash responder scripted per operation
  logic [31:0] cfg_exp = '0;
  int cfg_busy = 0, cfg_lat = 0;
  bit cfg_bad = 0;
  int rd_idx = 0, wcnt = 0;

  function automatic logic [31:0] flash_word(int idx);
    if (idx < cfg_busy)  return cfg_exp ^ 32'h0000_0080 ^ (32'h0101_0100 * idx);
    if (idx == cfg_busy) return cfg_exp ^ 32'h5A5A_0A00;  // bit 7 right, others settling
    return cfg_bad ? (cfg_exp ^ 32'h0001_0000) : cfg_exp;
  endfunction

  always @(negedge clk) begin
    if (!busy_o) rd_idx = 0;
    if (rd_ack_i) begin
      rd_ack_i = 1'b0;
      rd_data_i = 32'hDEAD_BEEF;
    end else if (rd_req_o) begin
      if (wcnt >= cfg_lat) begin
        rd_ack_i = 1'b1;
        rd_data_i = flash_word(rd_idx);
        rd_idx++;
        wcnt = 0;
      end else wcnt++;
    end
  end

  // behavioural reference: phase 0 idle,1 waiting read,2 judging,3 confirm,4 done,5 timeout
  int m_ph = 0, m_clk = 0, m_lim = 0;
  logic [31:0] m_exp = '0, m_got = '0;
  logic [23:0] m_addr = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_clk = 0; m_lim = 0; m_exp = '0; m_got = '0; m_addr = '0;
    end else begin
      case (m_ph)
        0: if (start_i) begin
             m_addr = start_addr_i;
             m_exp = start_erase_i ? 32'hFFFF_FFFF : start_data_i;
             m_lim = tmo_limit_i; m_clk = 0; m_ph = 1;
           end
        1: begin
             m_clk++;
             if (rd_ack_i) begin m_got = rd_data_i; m_ph = 2; end
           end
        2: begin
             if (m_got[7] == m_exp[7]) m_ph = 3;
             else if (m_clk >= m_lim) m_ph = 5;
             else m_ph = 1;
             m_clk++;
           end
        3: if (rd_ack_i) begin m_got = rd_data_i; m_ph = 4; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) if (rst_n) begin
    chk(rd_req_o == (m_ph == 1 || m_ph == 3), "R6 rd_req_o", rd_req_o, (m_ph == 1 || m_ph == 3));
    if (rd_req_o) chk(rd_addr_o == m_addr, "R8 rd_addr_o", rd_addr_o, m_addr);
    chk(busy_o == (m_ph != 0), "R8 busy_o", busy_o, (m_ph != 0));
    chk(done_o == (m_ph == 4), "R4 done_o", done_o, (m_ph == 4));
    chk(timeout_o == (m_ph == 5), "R7 timeout_o", timeout_o, (m_ph == 5));
    chk(mismatch_o == (m_ph == 4 && m_got != m_exp), "R5 mismatch_o", mismatch_o,
        (m_ph == 4 && m_got != m_exp));
  end

  task automatic run_op(input logic [23:0] a, input logic [31:0] d, input bit er,
                        input logic [15:0] lim, input int br, input int lt, input bit bad,
                        input bit poke, input bit exp_tmo, input int exp_reads, input string tag);
    bit got_done = 0, got_tmo = 0, got_mis = 0;
    int reads = 0;
    bit seen = 0;
    cfg_exp = er ? 32'hFFFF_FFFF : d;
    cfg_busy = br; cfg_lat = lt; cfg_bad = bad;
    @(negedge clk);
    start_i = 1'b1; start_addr_i = a; start_data_i = d;
    start_erase_i = er; tmo_limit_i = lim;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      start_i = 1'b0;
      start_data_i = ~d; start_erase_i = ~er; tmo_limit_i = 16'h0;
      if (done_o || timeout_o) begin
        got_done = done_o; got_tmo = timeout_o; got_mis = mismatch_o; reads = rd_idx;
        seen = 1;
        break;
      end
      if (poke && (n == 2 || n == 5)) begin
        start_i = 1'b1; start_addr_i = ~a; start_erase_i = 1'b1;
      end
    end
    start_i = 1'b0;
    chk(seen, {tag, " watchdog"}, seen, 1);
    chk(got_tmo == exp_tmo, {tag, " R7 timeout outcome"}, got_tmo, exp_tmo);
    chk(got_done == !exp_tmo, {tag, " R2 done outcome"}, got_done, !exp_tmo);
    if (!exp_tmo) chk(got_mis == bad, {tag, " R5 mismatch"}, got_mis, bad);
    if (exp_reads >= 0) chk(reads == exp_reads, {tag, " R4 read count"}, reads, exp_reads);
    repeat (2) @(negedge clk);
    chk(!busy_o && !rd_req_o, {tag, " R1 back to idle"}, busy_o, 0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !timeout_o && !mismatch_o && !rd_req_o, "R1 reset state",
        {busy_o, done_o, timeout_o, mismatch_o, rd_req_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R2 program, bit 7 set, no wait states
    run_op(24'h12_3456, 32'h1234_5680, 0, 16'd500, 3, 0, 0, 0, 0, 5, "prog_hi");
    // R2 R6 program, bit 7 clear, with wait states
    run_op(24'h00_0F00, 32'hCAFE_0013, 0, 16'd500, 2, 2, 0, 0, 0, 4, "prog_lo_wait");
    // R3 erase: start data ignored, expected all ones
    run_op(24'hAB_0000, 32'h0000_0000, 1, 16'd500, 4, 1, 0, 0, 0, 6, "erase");
    // R5 corrupted final word
    run_op(24'h55_5555, 32'h8000_00FF, 0, 16'd500, 1, 0, 1, 0, 0, 3, "prog_bad");
    run_op(24'h77_0001, 32'h0, 1, 16'd500, 2, 3, 1, 0, 0, 4, "erase_bad");
    // R4 first read already matches
    run_op(24'h00_0001, 32'h0000_0080, 0, 16'd500, 0, 0, 0, 0, 0, 2, "fast");
    // R7 timeouts
    run_op(24'h33_0000, 32'h0000_0080, 0, 16'd5, 1000, 0, 0, 0, 1, -1, "tmo5");
    run_op(24'h33_0004, 32'h0000_0000, 1, 16'd0, 1, 0, 0, 0, 1, 1, "tmo0");
    run_op(24'h33_0008, 32'h0000_0001, 0, 16'd40, 1000, 3, 0, 0, 1, -1, "tmo_wait");
    // R8 start while busy
    run_op(24'h0F_F0F0, 32'h1357_9BDF, 0, 16'd500, 5, 1, 0, 1, 0, 7, "poke");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule